// File: doc/BRIEF.md
# Command-Word Bridge to a Serial Controller's Byte Registers

This block sits between a host bus and the small bank of 8-bit registers inside a two-wire serial controller. The host never addresses those registers directly. It writes one 64-bit command word that carries a valid flag, a read flag, an operation code, a 3-bit internal address and a data field. The bridge then carries out the internal access over a fixed number of core cycles and clears the valid flag when it is done. The host polls the valid flag until it reads 0. For a read, the fetched byte is returned in the low byte of the data field of that same word.

The serial engine itself lies outside the block. Its view of the bank is a set of configuration outputs, a one-cycle engine reset pulse, and a status load port through which it reports its state. Every field sits at a fixed bit position in the 64-bit word and is taken out by mask and shift, so the layout is the same whatever the host's byte order.

Top module: `twi_cmd_bridge`

## Requirements
- R1: Reset clears the command word, busy, eng_rst and all five configuration outputs to 0.
- R2: Word fields are: valid in bit 63, operation code in bits 60:57, read flag in bit 56, internal address in bits 34:32, and data in bits 31:0. host_rdata always shows the stored word, and host_busy equals its bit 63.
- R3: A host write taken while idle, with bit 63 set, stores the word and starts an access. Valid stays set for exactly ACC_CYCLES cycles (default 2) and then clears.
- R4: Host writes while valid is set are ignored. The stored word does not change until the access completes.
- R5: A host write with bit 63 clear stores the word but performs no access and changes no register.
- R6: An op-6 write puts data[7:0] into the register selected by the address: 0 slave address, 1 data, 2 control, 3 clock control, 4 extended slave address. Addresses 5 and 6 have no effect.
- R7: An op-6 read sets data[7:0] to the register value and data[31:8] to 0, and keeps all other fields. Address 3 returns status, not clock control. Addresses 5, 6 and 7 return 0.
- R8: An access with an operation code other than 6 clears valid after the same latency and changes nothing else.
- R9: An op-6 write to address 7 raises eng_rst for exactly one cycle, in the first cycle that valid reads 0. It also sets status to 0xF8.
- R10: Status resets to 0xF8, and a pulse on eng_stat_we loads eng_stat. If both happen on the same edge, the soft reset from address 7 takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Current command word |
| host_busy | output | 1 | Access in progress (valid flag) |
| eng_stat_we | input | 1 | Engine status load strobe |
| eng_stat | input | 8 | Engine status value |
| eng_rst | output | 1 | One-cycle engine reset pulse |
| eng_sla | output | 8 | Slave address register |
| eng_dat | output | 8 | Data register |
| eng_ctl | output | 8 | Control register |
| eng_clk | output | 8 | Clock control register |
| eng_sla_ext | output | 8 | Extended slave address register |

## Verification
The assertions assume that reset is held for at least one clock before release and that ACC_CYCLES is at least 1. With those assumptions, every access keeps valid high for a whole number of cycles, and configuration outputs change only on the edge where valid falls. The bench keeps to this by asserting reset for several cycles. It changes inputs only on falling edges and drives eng_stat_we as a single-cycle strobe. It also deliberately issues host writes during busy periods, because the frozen-word property must hold exactly then.

// File: rtl/twi_cmd_bridge.sv
module twi_cmd_bridge #(
  parameter int         ACC_CYCLES = 2,
  parameter logic [7:0] STAT_IDLE  = 8'hF8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [63:0] host_wdata,
  output logic [63:0] host_rdata,
  output logic        host_busy,
  input  logic        eng_stat_we,
  input  logic [7:0]  eng_stat,
  output logic        eng_rst,
  output logic [7:0]  eng_sla,
  output logic [7:0]  eng_dat,
  output logic [7:0]  eng_ctl,
  output logic [7:0]  eng_clk,
  output logic [7:0]  eng_sla_ext
);
  localparam int         CNT_W   = (ACC_CYCLES > 1) ? $clog2(ACC_CYCLES) : 1;
  localparam int         V_BIT   = 63;
  localparam int         RD_BIT  = 56;
  localparam int         OP_LO   = 57;
  localparam int         AD_LO   = 32;
  localparam logic [3:0] OP_BANK = 4'd6;

  logic [63:0]      cmd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       sla_q, dat_q, ctl_q, clk_q, ext_q, stat_q;
  logic             rst_q;
  logic [7:0]       rd_byte;

  wire       busy   = cmd_q[V_BIT];
  wire       done   = busy && (cnt_q == '0);
  wire [3:0] op     = cmd_q[OP_LO+3:OP_LO];
  wire [2:0] addr   = cmd_q[AD_LO+2:AD_LO];
  wire       bank   = done && (op == OP_BANK);
  wire       do_wr  = bank && !cmd_q[RD_BIT];
  wire       do_rd  = bank &&  cmd_q[RD_BIT];
  wire [7:0] wbyte  = cmd_q[7:0];

  always_comb begin
    case (addr)
      3'd0:    rd_byte = sla_q;
      3'd1:    rd_byte = dat_q;
      3'd2:    rd_byte = ctl_q;
      3'd3:    rd_byte = stat_q;
      3'd4:    rd_byte = ext_q;
      default: rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == '0) begin
        cmd_q[V_BIT] <= 1'b0;
        if (do_rd) cmd_q[31:0] <= {24'h0, rd_byte};
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (host_we) begin
      cmd_q <= host_wdata;
      cnt_q <= CNT_W'(ACC_CYCLES - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sla_q <= '0;
      dat_q <= '0;
      ctl_q <= '0;
      clk_q <= '0;
      ext_q <= '0;
    end else if (do_wr) begin
      case (addr)
        3'd0:    sla_q <= wbyte;
        3'd1:    dat_q <= wbyte;
        3'd2:    ctl_q <= wbyte;
        3'd3:    clk_q <= wbyte;
        3'd4:    ext_q <= wbyte;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= STAT_IDLE;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= do_wr && (addr == 3'd7);
      if (do_wr && (addr == 3'd7)) stat_q <= STAT_IDLE;
      else if (eng_stat_we)        stat_q <= eng_stat;
    end
  end

  assign host_rdata  = cmd_q;
  assign host_busy   = busy;
  assign eng_rst     = rst_q;
  assign eng_sla     = sla_q;
  assign eng_dat     = dat_q;
  assign eng_ctl     = ctl_q;
  assign eng_clk     = clk_q;
  assign eng_sla_ext = ext_q;
endmodule

// File: rtl/twi_cmd_bridge_chk.sv
module twi_cmd_bridge_chk #(
  parameter int ACC_CYCLES = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] host_rdata,
  input logic        host_busy,
  input logic        eng_rst,
  input logic [7:0]  eng_sla,
  input logic [7:0]  eng_dat,
  input logic [7:0]  eng_ctl,
  input logic [7:0]  eng_clk,
  input logic [7:0]  eng_sla_ext
);
  logic [15:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         run_q <= '0;
    else if (host_busy) run_q <= run_q + 16'd1;
    else                run_q <= '0;
  end

  p_busy_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy |-> (run_q < 16'(ACC_CYCLES)));

  p_busy_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_busy) |-> (run_q == 16'(ACC_CYCLES)));

  p_valid_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy == host_rdata[63]);

  p_word_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_busy && $past(host_busy)) |-> $stable(host_rdata));

  p_cfg_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(host_busy) |->
      $stable({eng_sla, eng_dat, eng_ctl, eng_clk, eng_sla_ext}));

  p_rst_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |=> !eng_rst);

  p_rst_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_rst) |-> $fell(host_busy));
endmodule

bind twi_cmd_bridge twi_cmd_bridge_chk #(.ACC_CYCLES(ACC_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rdata(host_rdata), .host_busy(host_busy),
  .eng_rst(eng_rst), .eng_sla(eng_sla), .eng_dat(eng_dat), .eng_ctl(eng_ctl),
  .eng_clk(eng_clk), .eng_sla_ext(eng_sla_ext)
);

// File: tb/twi_cmd_bridge_tb.sv
module twi_cmd_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic        host_busy;
  logic        eng_stat_we = 1'b0;
  logic [7:0]  eng_stat = '0;
  logic        eng_rst;
  logic [7:0]  eng_sla, eng_dat, eng_ctl, eng_clk, eng_sla_ext;

  int tests = 0;
  int fails = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_cmd_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_busy(host_busy), .eng_stat_we(eng_stat_we),
    .eng_stat(eng_stat), .eng_rst(eng_rst), .eng_sla(eng_sla), .eng_dat(eng_dat),
    .eng_ctl(eng_ctl), .eng_clk(eng_clk), .eng_sla_ext(eng_sla_ext)
  );

  // behavioural reference model
  logic [63:0] m_cmd;
  int          m_cnt;
  logic [7:0]  m_reg [5];
  logic [7:0]  m_stat;
  logic        m_rst;

  always @(posedge clk) begin
    logic [7:0] old_stat;
    logic       srst;
    old_stat = m_stat;
    srst = 1'b0;
    if (!rst_n) begin
      m_cmd = '0; m_cnt = 0; m_stat = 8'hF8; m_rst = 1'b0;
      for (int i = 0; i < 5; i++) m_reg[i] = 8'h00;
    end else begin
      m_rst = 1'b0;
      if (m_cmd[63]) begin
        if (m_cnt == 0) begin
          m_cmd[63] = 1'b0;
          if (m_cmd[60:57] == 4'd6) begin
            int a;
            a = int'(m_cmd[34:32]);
            if (m_cmd[56]) begin
              logic [7:0] v;
              if (a == 3) v = old_stat;
              else if (a < 5) v = m_reg[a];
              else v = 8'h00;
              m_cmd[31:0] = {24'h0, v};
            end else if (a < 5) begin
              m_reg[a] = m_cmd[7:0];
            end else if (a == 7) begin
              srst = 1'b1;
            end
          end
        end else begin
          m_cnt--;
        end
      end else if (host_we) begin
        m_cmd = host_wdata;
        m_cnt = LAT - 1;
      end
      if (eng_stat_we) m_stat = eng_stat;
      if (srst) begin
        m_stat = 8'hF8;
        m_rst = 1'b1;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk("R4 word", host_rdata, m_cmd);
      chk("R3 busy", {63'h0, host_busy}, {63'h0, m_cmd[63]});
      chk("R9 eng_rst", {63'h0, eng_rst}, {63'h0, m_rst});
      chk("R6 cfg", {24'h0, eng_sla, eng_dat, eng_ctl, eng_clk, eng_sla_ext},
          {24'h0, m_reg[0], m_reg[1], m_reg[2], m_reg[3], m_reg[4]});
    end
  end

  function automatic logic [63:0] mk(bit v, logic [3:0] op, bit rd,
                                     logic [2:0] a, logic [31:0] d);
    logic [63:0] w;
    w = '0;
    w[63] = v; w[60:57] = op; w[56] = rd; w[34:32] = a; w[31:0] = d;
    return w;
  endfunction

  task automatic issue(input logic [63:0] w);
    host_we = 1'b1; host_wdata = w;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (host_busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic acc(input logic [63:0] w);
    int n;
    issue(w);
    wait_idle(n);
    chk("R3 latency", 64'(n), 64'(LAT));
  endtask

  task automatic rd_reg(input logic [2:0] a, input logic [7:0] exp, input string req);
    acc(mk(1, 4'd6, 1, a, 32'hCAFE_BE11));
    chk(req, host_rdata[31:0], {24'h0, exp});
    chk("R7 fields kept", host_rdata[63:32], mk(0, 4'd6, 1, a, 0) >> 32);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done_flag) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 word", host_rdata, 64'h0);
    chk("R1 busy", {63'h0, host_busy}, 64'h0);
    chk("R1 rst", {63'h0, eng_rst}, 64'h0);
    chk("R1 cfg", {24'h0, eng_sla, eng_dat, eng_ctl, eng_clk, eng_sla_ext}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 status after reset, R7 read path
    rd_reg(3'd3, 8'hF8, "R10 reset status");

    // R6 writes to each register
    acc(mk(1, 4'd6, 0, 3'd0, 32'h0000_0077));
    chk("R6 slave addr", {56'h0, eng_sla}, 64'h77);
    acc(mk(1, 4'd6, 0, 3'd1, 32'hFFFF_FF5A));
    acc(mk(1, 4'd6, 0, 3'd2, 32'h0000_0044));
    acc(mk(1, 4'd6, 0, 3'd3, 32'h0000_002B));
    chk("R6 clock ctl", {56'h0, eng_clk}, 64'h2B);
    acc(mk(1, 4'd6, 0, 3'd4, 32'h0000_0013));
    acc(mk(1, 4'd6, 0, 3'd5, 32'h0000_0099));
    acc(mk(1, 4'd6, 0, 3'd6, 32'h0000_0088));
    chk("R6 ignored addr", {24'h0, eng_sla, eng_dat, eng_ctl, eng_clk, eng_sla_ext},
        {24'h0, 8'h77, 8'h5A, 8'h44, 8'h2B, 8'h13});

    // R7 read-back
    rd_reg(3'd0, 8'h77, "R7 read slave");
    rd_reg(3'd1, 8'h5A, "R7 read data");
    rd_reg(3'd3, 8'hF8, "R7 addr3 is status");
    rd_reg(3'd5, 8'h00, "R7 addr5 zero");
    rd_reg(3'd7, 8'h00, "R7 addr7 zero");

    // R10 engine status load
    eng_stat_we = 1'b1; eng_stat = 8'h18;
    @(negedge clk);
    eng_stat_we = 1'b0;
    rd_reg(3'd3, 8'h18, "R10 engine status");

    // R9 soft reset
    issue(mk(1, 4'd6, 0, 3'd7, 32'h0));
    wait_idle(n);
    chk("R9 pulse at done", {63'h0, eng_rst}, 64'h1);
    @(negedge clk);
    chk("R9 pulse one cycle", {63'h0, eng_rst}, 64'h0);
    rd_reg(3'd3, 8'hF8, "R9 status idle");

    // R10 soft reset wins over same-edge status load
    eng_stat_we = 1'b1; eng_stat = 8'h20;
    @(negedge clk);
    eng_stat_we = 1'b0;
    issue(mk(1, 4'd6, 0, 3'd7, 32'h0));
    @(negedge clk);
    eng_stat_we = 1'b1; eng_stat = 8'h33;
    @(negedge clk);
    eng_stat_we = 1'b0;
    rd_reg(3'd3, 8'hF8, "R10 soft reset priority");

    // R8 other operation code
    acc(mk(1, 4'd3, 0, 3'd0, 32'h0000_00EE));
    chk("R8 word kept", host_rdata, mk(0, 4'd3, 0, 3'd0, 32'h0000_00EE));
    chk("R8 no reg change", {56'h0, eng_sla}, 64'h77);

    // R4 write during busy ignored
    issue(mk(1, 4'd6, 0, 3'd2, 32'h0000_00C3));
    issue(mk(1, 4'd6, 0, 3'd0, 32'h0000_0011));
    wait_idle(n);
    chk("R4 ignored write", host_rdata, mk(0, 4'd6, 0, 3'd2, 32'h0000_00C3));
    chk("R4 slave kept", {56'h0, eng_sla}, 64'h77);
    chk("R4 ctl taken", {56'h0, eng_ctl}, 64'hC3);

    // R5 write with valid clear
    issue(mk(0, 4'd6, 0, 3'd1, 32'h1234_5600));
    chk("R5 stored", host_rdata, mk(0, 4'd6, 0, 3'd1, 32'h1234_5600));
    chk("R5 not busy", {63'h0, host_busy}, 64'h0);
    repeat (3) @(negedge clk);
    chk("R5 data kept", {56'h0, eng_dat}, 64'h5A);

    // R2 field positions survive completion
    acc({1'b1, 2'b10, 4'd6, 1'b1, 21'h1ABCDE, 3'd4, 32'h0});
    chk("R2 layout", host_rdata, {1'b0, 2'b10, 4'd6, 1'b1, 21'h1ABCDE, 3'd4, 32'h13});

    repeat (2) @(negedge clk);
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule